// File: doc/BRIEF.md
# Constant Plus/Minus Five Unit

This combinational block takes a 4-bit unsigned operand and one control bit. With the control bit low it returns the operand increased by five. With the control bit high it returns the operand reduced by five. The main result comes from a single ripple adder. The adder's second operand is picked per bit by a quad 2:1 selector, which chooses between the constant 0101 and the constant 1011 (the two's complement of five). The carry-in is zero and the carry-out is dropped.

A second, independent realization produces each result bit through a different structure:

- The top bit uses a 32-line minterm decoder built from a 2:4 group decoder and four enabled 3:8 decoders.
- Bit 2 uses a 4:1 selector addressed by the two low operand bits.
- Bit 1 uses a 1:32 routing tree of 1:4 demultiplexers.
- Bit 0 uses a one-hot 2:4 decoder that picks one of four fixed driver values.

An agreement flag compares the adder result with the rebuilt bits. The flag lets a system confirm that the two derivations match.

Operand and control combinations whose true result would leave the range 0..15 are treated as never occurring. The block does no overflow or borrow handling.

Top module: `pm5_unit`

## Requirements
- R1: With `k_i` = 0 and `n_i` in 0..10, `m_o` equals `n_i` + 5.
- R2: With `k_i` = 1 and `n_i` in 5..15, `m_o` equals `n_i` − 5.
- R3: For every in-range combination (R1 or R2 ranges), `agree_o` is 1.
- R4: For every in-range combination, bit 0 of `m_o` is the inverse of bit 0 of `n_i`.
- R5: The block holds no state. The same `n_i`/`k_i` pair gives the same `m_o` and `agree_o` whatever inputs came before it.
- R6: The range ends map exactly: N=0,K=0 gives 5; N=10,K=0 gives 15; N=5,K=1 gives 0; N=15,K=1 gives 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| n_i | input | 4 | Unsigned operand |
| k_i | input | 1 | 0 selects add five, 1 selects subtract five |
| m_o | output | 4 | Adder-path result |
| agree_o | output | 1 | High when the per-bit alternative realization matches `m_o` |

## Verification
The block has no parameters, so the bench builds it exactly as written. With only five input bits, the bench walks every one of the 22 in-range operand/control pairs. This covers each minterm line the top-bit decoder and the bit-1 routing tree can select, and all four select codes of both the bit-2 selector and the bit-0 decoder. Out-of-range pairs are applied only as preceding history, to show that no earlier input affects a later result.

// File: rtl/pm5_unit.sv
module pm5_unit (
  input  logic [3:0] n_i,
  input  logic       k_i,
  output logic [3:0] m_o,
  output logic       agree_o
);

  localparam int W = 4;
  localparam int CODES = 2 ** (W + 1);
  localparam logic [W-1:0] ADD_CONST = 4'b0101;
  localparam logic [W-1:0] SUB_CONST = 4'b1011;
  localparam logic [CODES-1:0] TOP_SET = 32'hE000_07F8;
  localparam logic [CODES-1:0] B1_SET  = 32'h9980_0666;
  localparam logic [3:0] LSB_DRV = 4'b0101;

  logic [W-1:0] opb;
  logic [W:0]   cy;
  logic [W-1:0] sum;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_sel
      assign opb[gi] = k_i ? SUB_CONST[gi] : ADD_CONST[gi];
    end
  endgenerate

  assign cy[0] = 1'b0;
  generate
    for (gi = 0; gi < W; gi++) begin : g_add
      assign sum[gi]  = n_i[gi] ^ opb[gi] ^ cy[gi];
      assign cy[gi+1] = (n_i[gi] & opb[gi]) | (cy[gi] & (n_i[gi] ^ opb[gi]));
    end
  endgenerate

  assign m_o = sum;

  logic [3:0]       grp_en;
  logic [CODES-1:0] mint;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_grp
      assign grp_en[gi] = ({k_i, n_i[3]} == gi[1:0]);
      for (genvar gj = 0; gj < 8; gj++) begin : g_line
        assign mint[gi*8+gj] = grp_en[gi] & (n_i[2:0] == gj[2:0]);
      end
    end
  endgenerate
  logic alt3;
  assign alt3 = |(mint & TOP_SET);

  logic [3:0] d2;
  assign d2[0] = ~(n_i[2] ^ k_i);
  assign d2[1] = ~n_i[2];
  assign d2[2] = ~n_i[2];
  assign d2[3] = n_i[2] ^ k_i;
  logic alt2;
  assign alt2 = d2[n_i[1:0]];

  logic [3:0]       rt0;
  logic [7:0]       rt1;
  logic [CODES-1:0] rt2;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_rt0
      assign rt0[gi] = ({1'b0, k_i} == gi[1:0]);
    end
    for (gi = 0; gi < 2; gi++) begin : g_rt1
      for (genvar gj = 0; gj < 4; gj++) begin : g_o
        assign rt1[gi*4+gj] = rt0[gi] & (n_i[3:2] == gj[1:0]);
      end
    end
    for (gi = 0; gi < 8; gi++) begin : g_rt2
      for (genvar gj = 0; gj < 4; gj++) begin : g_o
        assign rt2[gi*4+gj] = rt1[gi] & (n_i[1:0] == gj[1:0]);
      end
    end
  endgenerate
  logic alt1;
  assign alt1 = |(rt2 & B1_SET);

  logic [3:0] drv_en;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_drv
      assign drv_en[gi] = (n_i[1:0] == gi[1:0]);
    end
  endgenerate
  logic alt0;
  assign alt0 = |(drv_en & LSB_DRV);

  assign agree_o = (sum == {alt3, alt2, alt1, alt0});

endmodule

module pm5_unit_chk (
  input logic [3:0] n_i,
  input logic       k_i,
  input logic [3:0] m_o,
  input logic       agree_o
);
  logic in_rng;
  assign in_rng = k_i ? (n_i >= 4'd5) : (n_i <= 4'd10);

  always_comb begin
    if (in_rng && !k_i) p_add_r1: assert (m_o == n_i + 4'd5);
    if (in_rng && k_i)  p_sub_r2: assert (m_o == n_i - 4'd5);
    if (in_rng)         p_agree_r3: assert (agree_o);
    if (in_rng)         p_lsb_r4: assert (m_o[0] != n_i[0]);
    if (in_rng)         p_top_r1_r2: assert (m_o[3] == ((k_i ? n_i - 4'd5 : n_i + 4'd5) >= 4'd8));
  end
endmodule

bind pm5_unit pm5_unit_chk chk_i (
  .n_i(n_i), .k_i(k_i), .m_o(m_o), .agree_o(agree_o)
);

// File: tb/pm5_unit_tb_top.sv
`timescale 1ns/1ps
module pm5_unit_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] n;
  logic       k;
  logic [3:0] m;
  logic       agree;
  int total = 0;
  int bad = 0;
  bit done = 0;

  pm5_unit dut_i (.n_i(n), .k_i(k), .m_o(m), .agree_o(agree));

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d exp=%0d (n=%0d k=%0d)", req, got, exp, n, k);
    end
  endtask

  task automatic apply(int nv, int kv);
    @(negedge clk);
    n = nv[3:0];
    k = kv[0];
    #1;
  endtask

  task automatic t_first;
    apply(0, 0);
    chk("R1 first", m, 5);
    chk("R3 first", agree, 1);
  endtask

  task automatic t_add_sweep;
    for (int i = 0; i <= 10; i++) begin
      apply(i, 0);
      chk("R1", m, i + 5);
      chk("R3", agree, 1);
      chk("R4", m[0], ~i & 1);
    end
  endtask

  task automatic t_sub_sweep;
    for (int i = 15; i >= 5; i--) begin
      apply(i, 1);
      chk("R2", m, i - 5);
      chk("R3", agree, 1);
      chk("R4", m[0], ~i & 1);
    end
  endtask

  task automatic t_ends;
    apply(0, 0);  chk("R6 lo add", m, 5);
    apply(10, 0); chk("R6 hi add", m, 15);
    apply(5, 1);  chk("R6 lo sub", m, 0);
    apply(15, 1); chk("R6 hi sub", m, 10);
  endtask

  task automatic t_history;
    apply(14, 0);
    apply(7, 0); chk("R5 after oor", m, 12); chk("R5 agree", agree, 1);
    apply(2, 1);
    apply(7, 0); chk("R5 after sub", m, 12);
    apply(7, 1); chk("R5 k flip", m, 2); chk("R5 agree k", agree, 1);
    apply(13, 0);
    apply(7, 1); chk("R5 repeat", m, 2);
  endtask

  initial begin
    n = '0;
    k = 1'b0;
    t_first();
    t_add_sweep();
    t_sub_sweep();
    t_ends();
    t_history();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule